// File: doc/BRIEF.md
# Memory dependence wait scoreboard

This block holds the load and store instructions of an out-of-order core that are waiting to go to memory and decides when each may issue. An instruction may only leave when two conditions are both true: its register operands are available, and any older store that a dependence predictor expects it to follow has already issued. On insertion the block asks an external predictor, using the instruction PC, for the sequence number of a producing store. If that store is still held here, the new entry is linked to the store's slot and waits for it.

Every cycle the block offers the ready entry with the lowest sequence number as the issue candidate. Popping a store wakes the entries linked to it. A squash by sequence number removes all younger entries, including stores that other entries wait on. Instructions that must not issue speculatively enter on a separate path and leave only when an explicit release names them. Store insertions, issues and ordering violations are reported to the predictor one cycle later. Four event counters record inserted loads and stores and the loads and stores that were linked to a producer.

Top module: `mdw_scoreboard`

## Requirements
- R1: An accepted insert with no memory dependence (predictor answer 0, or a store sequence number not held in the block) and `ins_regs_rdy`=1 becomes an issue candidate in the cycle after the insert.
- R2: An entry with no dependence and `ins_regs_rdy`=0 waits. A register-ready strobe `rr_valid` with `rr_seq` equal to its sequence number makes it ready one cycle later.
- R3: An insert whose predicted producer is a store held in the block and not popped in the same cycle waits even if its registers are ready, and increments the conflicting-load or conflicting-store counter according to its type.
- R4: An accepted store insert drives `pred_st_valid`=1 with its PC and sequence number in the following cycle. A store may not be inserted with a sequence number already held by a store.
- R5: Popping a store makes its linked entries with ready registers ready in the next cycle, and the other linked entries then need only a register-ready strobe. Popping a load releases nothing.
- R6: An entry inserted with `ins_nonspec`=1 ignores register-ready strobes and becomes ready only one cycle after `nsr_valid` with `nsr_seq` equal to its sequence number.
- R7: `iss_seq` is the lowest sequence number among the ready entries. `iss_pop` with `iss_valid`=1 removes that entry, and in the next cycle `pred_iss_valid`=1 reports its PC, sequence number and store flag (1 = store).
- R8: `sq_valid` with `sq_seq`=N removes every entry whose sequence number is greater than N. Removed stores release nothing later. Insert, register-ready, release and pop inputs in a squash cycle are ignored.
- R9: `vio_valid` with a load PC and a store PC is passed unchanged to `pred_vio_*` one cycle later.
- R10: `cnt_ins_ld`, `cnt_ins_st`, `cnt_conf_ld` and `cnt_conf_st` reset to 0 and each rises by one per accepted insert of its kind.
- R11: `ins_full` is 1 exactly when all ENTRIES slots are occupied. An insert while full is ignored.
- R12: `pred_lk_pc` follows `ins_pc` in the same cycle, so that `pred_producer` can answer combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert request |
| ins_seq | input | SEQ_W | Sequence number of the inserted instruction |
| ins_pc | input | PC_W | PC of the inserted instruction |
| ins_is_store | input | 1 | 1 = store, 0 = load |
| ins_regs_rdy | input | 1 | Register operands already available |
| ins_nonspec | input | 1 | Non-speculative path, released only by nsr |
| ins_full | output | 1 | All slots occupied |
| pred_lk_pc | output | PC_W | PC sent to the predictor lookup |
| pred_producer | input | SEQ_W | Predicted producer store sequence number, 0 = none |
| rr_valid | input | 1 | Register-ready strobe |
| rr_seq | input | SEQ_W | Sequence number for the register-ready strobe |
| nsr_valid | input | 1 | Non-speculative release strobe |
| nsr_seq | input | SEQ_W | Sequence number to release |
| iss_valid | output | 1 | An issue candidate exists |
| iss_seq | output | SEQ_W | Candidate sequence number |
| iss_pc | output | PC_W | Candidate PC |
| iss_is_store | output | 1 | Candidate is a store |
| iss_pop | input | 1 | Take the candidate |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Entries younger than this are removed |
| vio_valid | input | 1 | Ordering violation seen |
| vio_load_pc | input | PC_W | Violating load PC |
| vio_store_pc | input | PC_W | Store PC of the violation |
| pred_st_valid | output | 1 | Store insert report |
| pred_st_seq | output | SEQ_W | Reported store sequence number |
| pred_st_pc | output | PC_W | Reported store PC |
| pred_iss_valid | output | 1 | Issue report |
| pred_iss_seq | output | SEQ_W | Issued sequence number |
| pred_iss_pc | output | PC_W | Issued PC |
| pred_iss_store | output | 1 | Issued instruction was a store |
| pred_vio_valid | output | 1 | Forwarded violation |
| pred_vio_load_pc | output | PC_W | Forwarded load PC |
| pred_vio_store_pc | output | PC_W | Forwarded store PC |
| cnt_ins_ld | output | CNT_W | Inserted loads |
| cnt_ins_st | output | CNT_W | Inserted stores |
| cnt_conf_ld | output | CNT_W | Loads linked to a producer |
| cnt_conf_st | output | CNT_W | Stores linked to a producer |

## Verification
A stale producer link or a lost flag is visible at the issue port: the affected entry either appears as a candidate one cycle after insert, wake or squash when it should not, or never appears, and its sequence number then breaks the ascending order that the bench expects from successive pops. A wrong slot pick or a broken squash shows as an early `ins_full`, as an insert that is dropped, or as a candidate whose number lies above the squash point. The bench fills the whole array and drains a permuted set in order, so occupancy and ordering faults show up within one pass of at most sixteen inserts and pops.

// File: rtl/mdw_pkg.sv
package mdw_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE  = 2'd0,
    SLOT_WAIT  = 2'd1,
    SLOT_READY = 2'd2
  } slot_state_e;

  localparam int unsigned NUM_STATS = 4;
  localparam int unsigned STAT_LD   = 0;
  localparam int unsigned STAT_ST   = 1;
  localparam int unsigned STAT_CLD  = 2;
  localparam int unsigned STAT_CST  = 3;
endpackage

// File: rtl/mdw_first_set.sv
module mdw_first_set #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mdw_oldest.sv
module mdw_oldest #(
  parameter int unsigned N     = 16,
  parameter int unsigned SEQ_W = 8,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]            rdy,
  input  logic [N-1:0][SEQ_W-1:0] seqs,
  output logic                    any,
  output logic [IDX_W-1:0]        idx
);
  logic [SEQ_W-1:0] best_seq;

  always_comb begin
    any      = 1'b0;
    idx      = '0;
    best_seq = '0;
    for (int i = 0; i < N; i++) begin
      if (rdy[i] && (!any || seqs[i] < best_seq)) begin
        any      = 1'b1;
        idx      = IDX_W'(i);
        best_seq = seqs[i];
      end
    end
  end

  // R7: the chosen slot is never younger than another ready slot
  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (any && rdy[i]) begin
        a_oldest_r7: assert (seqs[idx] <= seqs[i]);
      end
    end
  end
endmodule

// File: rtl/mdw_stats.sv
module mdw_stats #(
  parameter int unsigned NUM   = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM-1:0]            inc,
  output logic [NUM-1:0][CNT_W-1:0] cnt
);
  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt[g] <= '0;
      end else if (inc[g]) begin
        cnt[g] <= cnt[g] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdw_scoreboard.sv
module mdw_scoreboard
  import mdw_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned SEQ_W   = 8,
  parameter int unsigned PC_W    = 16,
  parameter int unsigned CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_valid,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic [PC_W-1:0]  ins_pc,
  input  logic             ins_is_store,
  input  logic             ins_regs_rdy,
  input  logic             ins_nonspec,
  output logic             ins_full,
  output logic [PC_W-1:0]  pred_lk_pc,
  input  logic [SEQ_W-1:0] pred_producer,
  input  logic             rr_valid,
  input  logic [SEQ_W-1:0] rr_seq,
  input  logic             nsr_valid,
  input  logic [SEQ_W-1:0] nsr_seq,
  output logic             iss_valid,
  output logic [SEQ_W-1:0] iss_seq,
  output logic [PC_W-1:0]  iss_pc,
  output logic             iss_is_store,
  input  logic             iss_pop,
  input  logic             sq_valid,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic             vio_valid,
  input  logic [PC_W-1:0]  vio_load_pc,
  input  logic [PC_W-1:0]  vio_store_pc,
  output logic             pred_st_valid,
  output logic [SEQ_W-1:0] pred_st_seq,
  output logic [PC_W-1:0]  pred_st_pc,
  output logic             pred_iss_valid,
  output logic [SEQ_W-1:0] pred_iss_seq,
  output logic [PC_W-1:0]  pred_iss_pc,
  output logic             pred_iss_store,
  output logic             pred_vio_valid,
  output logic [PC_W-1:0]  pred_vio_load_pc,
  output logic [PC_W-1:0]  pred_vio_store_pc,
  output logic [CNT_W-1:0] cnt_ins_ld,
  output logic [CNT_W-1:0] cnt_ins_st,
  output logic [CNT_W-1:0] cnt_conf_ld,
  output logic [CNT_W-1:0] cnt_conf_st
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // Slot storage, one array per field
  slot_state_e                    e_state [ENTRIES];
  logic [ENTRIES-1:0][SEQ_W-1:0]  e_seq;
  logic [PC_W-1:0]                e_pc    [ENTRIES];
  logic [ENTRIES-1:0]             e_store;
  logic [ENTRIES-1:0]             e_nspec;
  logic [ENTRIES-1:0]             e_regs;
  logic [ENTRIES-1:0]             e_mem;
  logic [ENTRIES-1:0]             e_link;
  logic [IDX_W-1:0]               e_prod  [ENTRIES];

  // Per-slot decode
  logic [ENTRIES-1:0] v_used, v_free, v_ready, v_kill;
  logic [ENTRIES-1:0] v_rr, v_nsr, v_wake, v_prod, v_dup;

  logic             free_any, prod_any, cand_any;
  logic [IDX_W-1:0] free_idx, prod_idx, cand_idx;
  logic             pop_go, pop_store, ins_go, ins_dep;

  assign pred_lk_pc = ins_pc;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      v_used[i]  = (e_state[i] != SLOT_FREE);
      v_free[i]  = (e_state[i] == SLOT_FREE);
      v_ready[i] = (e_state[i] == SLOT_READY);
      v_kill[i]  = v_used[i] && (e_seq[i] > sq_seq);
      v_rr[i]    = rr_valid && (e_state[i] == SLOT_WAIT) && !e_nspec[i]
                   && (e_seq[i] == rr_seq);
      v_nsr[i]   = nsr_valid && (e_state[i] == SLOT_WAIT) && e_nspec[i]
                   && (e_seq[i] == nsr_seq);
      v_dup[i]   = v_used[i] && e_store[i] && (e_seq[i] == ins_seq);
      v_prod[i]  = v_used[i] && e_store[i] && (pred_producer != '0)
                   && (e_seq[i] == pred_producer)
                   && !(pop_go && (cand_idx == IDX_W'(i)));
    end
  end

  mdw_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) i_free_pick (
    .vec (v_free),
    .any (free_any),
    .idx (free_idx)
  );

  mdw_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) i_prod_pick (
    .vec (v_prod),
    .any (prod_any),
    .idx (prod_idx)
  );

  mdw_oldest #(.N(ENTRIES), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) i_oldest (
    .rdy  (v_ready),
    .seqs (e_seq),
    .any  (cand_any),
    .idx  (cand_idx)
  );

  assign ins_full     = !free_any;
  assign iss_valid    = cand_any;
  assign iss_seq      = e_seq[cand_idx];
  assign iss_pc       = e_pc[cand_idx];
  assign iss_is_store = e_store[cand_idx];

  assign pop_go    = iss_pop && cand_any && !sq_valid;
  assign pop_store = pop_go && e_store[cand_idx];
  assign ins_go    = ins_valid && free_any && !sq_valid;
  assign ins_dep   = !ins_nonspec && prod_any;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      v_wake[i] = pop_store && (e_state[i] == SLOT_WAIT) && e_link[i]
                  && (e_prod[i] == cand_idx);
    end
  end

  // Slot state update
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic regs_n, mem_n;
    assign regs_n = e_regs[g] || v_rr[g];
    assign mem_n  = e_mem[g] || v_wake[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        e_state[g] <= SLOT_FREE;
        e_seq[g]   <= '0;
        e_pc[g]    <= '0;
        e_store[g] <= 1'b0;
        e_nspec[g] <= 1'b0;
        e_regs[g]  <= 1'b0;
        e_mem[g]   <= 1'b0;
        e_link[g]  <= 1'b0;
        e_prod[g]  <= '0;
      end else if (sq_valid) begin
        if (v_kill[g]) begin
          e_state[g] <= SLOT_FREE;
          e_link[g]  <= 1'b0;
        end else if (e_state[g] == SLOT_WAIT && e_link[g] && v_kill[e_prod[g]]) begin
          // producer vanished: nothing left to wait for on the memory side
          e_link[g] <= 1'b0;
          e_mem[g]  <= 1'b1;
          if (e_regs[g]) e_state[g] <= SLOT_READY;
        end
      end else if (ins_go && free_idx == IDX_W'(g)) begin
        e_seq[g]   <= ins_seq;
        e_pc[g]    <= ins_pc;
        e_store[g] <= ins_is_store;
        e_nspec[g] <= ins_nonspec;
        e_regs[g]  <= ins_regs_rdy;
        e_mem[g]   <= !ins_dep && !ins_nonspec;
        e_link[g]  <= ins_dep;
        e_prod[g]  <= prod_idx;
        e_state[g] <= (!ins_dep && !ins_nonspec && ins_regs_rdy) ? SLOT_READY : SLOT_WAIT;
      end else if (pop_go && cand_idx == IDX_W'(g)) begin
        e_state[g] <= SLOT_FREE;
        e_link[g]  <= 1'b0;
      end else if (e_state[g] == SLOT_WAIT) begin
        if (e_nspec[g]) begin
          if (v_nsr[g]) e_state[g] <= SLOT_READY;
        end else begin
          e_regs[g] <= regs_n;
          e_mem[g]  <= mem_n;
          if (v_wake[g]) e_link[g] <= 1'b0;
          if (regs_n && mem_n) e_state[g] <= SLOT_READY;
        end
      end
    end
  end

  // Registered reports toward the predictor
  always_ff @(posedge clk) begin
    if (rst) begin
      pred_st_valid     <= 1'b0;
      pred_st_seq       <= '0;
      pred_st_pc        <= '0;
      pred_iss_valid    <= 1'b0;
      pred_iss_seq      <= '0;
      pred_iss_pc       <= '0;
      pred_iss_store    <= 1'b0;
      pred_vio_valid    <= 1'b0;
      pred_vio_load_pc  <= '0;
      pred_vio_store_pc <= '0;
    end else begin
      pred_st_valid  <= ins_go && ins_is_store;
      pred_iss_valid <= pop_go;
      pred_vio_valid <= vio_valid;
      if (ins_go && ins_is_store) begin
        pred_st_seq <= ins_seq;
        pred_st_pc  <= ins_pc;
      end
      if (pop_go) begin
        pred_iss_seq   <= iss_seq;
        pred_iss_pc    <= iss_pc;
        pred_iss_store <= iss_is_store;
      end
      if (vio_valid) begin
        pred_vio_load_pc  <= vio_load_pc;
        pred_vio_store_pc <= vio_store_pc;
      end
    end
  end

  // Event counters
  logic [NUM_STATS-1:0]            stat_inc;
  logic [NUM_STATS-1:0][CNT_W-1:0] stat_cnt;

  always_comb begin
    stat_inc           = '0;
    stat_inc[STAT_LD]  = ins_go && !ins_is_store;
    stat_inc[STAT_ST]  = ins_go && ins_is_store;
    stat_inc[STAT_CLD] = ins_go && ins_dep && !ins_is_store;
    stat_inc[STAT_CST] = ins_go && ins_dep && ins_is_store;
  end

  mdw_stats #(.NUM(NUM_STATS), .CNT_W(CNT_W)) i_stats (
    .clk (clk),
    .rst (rst),
    .inc (stat_inc),
    .cnt (stat_cnt)
  );

  assign cnt_ins_ld  = stat_cnt[STAT_LD];
  assign cnt_ins_st  = stat_cnt[STAT_ST];
  assign cnt_conf_ld = stat_cnt[STAT_CLD];
  assign cnt_conf_st = stat_cnt[STAT_CST];

  // Assertions
  p_no_dup_store_r4: assert property (@(posedge clk) disable iff (rst)
    (ins_go && ins_is_store) |-> (v_dup == '0));

  p_store_report_r4: assert property (@(posedge clk) disable iff (rst)
    (ins_go && ins_is_store) |=> (pred_st_valid && pred_st_seq == $past(ins_seq)));

  p_pop_report_r7: assert property (@(posedge clk) disable iff (rst)
    (iss_pop && iss_valid && !sq_valid) |=>
      (pred_iss_valid && pred_iss_seq == $past(iss_seq)
       && pred_iss_store == $past(iss_is_store)));

  p_squash_bound_r8: assert property (@(posedge clk) disable iff (rst)
    sq_valid |=> (!iss_valid || iss_seq <= $past(sq_seq)));

  p_vio_forward_r9: assert property (@(posedge clk) disable iff (rst)
    vio_valid |=> (pred_vio_valid && pred_vio_load_pc == $past(vio_load_pc)
                   && pred_vio_store_pc == $past(vio_store_pc)));

  p_full_drop_r11: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_full) |=> ($stable(cnt_ins_ld) && $stable(cnt_ins_st)));
endmodule

// File: tb/test_mdw_scoreboard.sv
module test_mdw_scoreboard;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned ENTRIES = 16;
  localparam int unsigned SEQ_W = 8;
  localparam int unsigned PC_W = 16;
  localparam int unsigned CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ins_valid = 0, ins_is_store = 0, ins_regs_rdy = 0, ins_nonspec = 0;
  logic [SEQ_W-1:0] ins_seq = '0, pred_producer = '0, rr_seq = '0, nsr_seq = '0, sq_seq = '0;
  logic [PC_W-1:0] ins_pc = '0, vio_load_pc = '0, vio_store_pc = '0;
  logic rr_valid = 0, nsr_valid = 0, iss_pop = 0, sq_valid = 0, vio_valid = 0;
  logic ins_full, iss_valid, iss_is_store, pred_st_valid, pred_iss_valid, pred_iss_store, pred_vio_valid;
  logic [PC_W-1:0] pred_lk_pc, iss_pc, pred_st_pc, pred_iss_pc, pred_vio_load_pc, pred_vio_store_pc;
  logic [SEQ_W-1:0] iss_seq, pred_st_seq, pred_iss_seq;
  logic [CNT_W-1:0] cnt_ins_ld, cnt_ins_st, cnt_conf_ld, cnt_conf_st;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mdw_scoreboard #(.ENTRIES(ENTRIES), .SEQ_W(SEQ_W), .PC_W(PC_W), .CNT_W(CNT_W)) i_mdw_scoreboard (
    .clk(clk), .rst(rst),
    .ins_valid(ins_valid), .ins_seq(ins_seq), .ins_pc(ins_pc), .ins_is_store(ins_is_store),
    .ins_regs_rdy(ins_regs_rdy), .ins_nonspec(ins_nonspec), .ins_full(ins_full),
    .pred_lk_pc(pred_lk_pc), .pred_producer(pred_producer),
    .rr_valid(rr_valid), .rr_seq(rr_seq), .nsr_valid(nsr_valid), .nsr_seq(nsr_seq),
    .iss_valid(iss_valid), .iss_seq(iss_seq), .iss_pc(iss_pc), .iss_is_store(iss_is_store),
    .iss_pop(iss_pop), .sq_valid(sq_valid), .sq_seq(sq_seq),
    .vio_valid(vio_valid), .vio_load_pc(vio_load_pc), .vio_store_pc(vio_store_pc),
    .pred_st_valid(pred_st_valid), .pred_st_seq(pred_st_seq), .pred_st_pc(pred_st_pc),
    .pred_iss_valid(pred_iss_valid), .pred_iss_seq(pred_iss_seq), .pred_iss_pc(pred_iss_pc),
    .pred_iss_store(pred_iss_store), .pred_vio_valid(pred_vio_valid),
    .pred_vio_load_pc(pred_vio_load_pc), .pred_vio_store_pc(pred_vio_store_pc),
    .cnt_ins_ld(cnt_ins_ld), .cnt_ins_st(cnt_ins_st), .cnt_conf_ld(cnt_conf_ld), .cnt_conf_st(cnt_conf_st)
  );

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cand(input string tag, input logic v, input logic [SEQ_W-1:0] s);
    chk({tag, " valid"}, 32'(iss_valid), 32'(v));
    if (v) chk({tag, " seq"}, 32'(iss_seq), 32'(s));
  endtask

  task automatic ins(input logic [SEQ_W-1:0] s, input logic [PC_W-1:0] pc, input logic st,
                     input logic rdy, input logic ns, input logic [SEQ_W-1:0] prod);
    ins_valid = 1; ins_seq = s; ins_pc = pc; ins_is_store = st;
    ins_regs_rdy = rdy; ins_nonspec = ns; pred_producer = prod;
    tick();
    ins_valid = 0; pred_producer = '0;
  endtask

  task automatic regs(input logic [SEQ_W-1:0] s);
    rr_valid = 1; rr_seq = s; tick(); rr_valid = 0;
  endtask

  task automatic squash(input logic [SEQ_W-1:0] n);
    sq_valid = 1; sq_seq = n; tick(); sq_valid = 0;
  endtask

  task automatic pop_chk(input string tag, input logic [SEQ_W-1:0] s, input logic st);
    cand({tag, " cand"}, 1'b1, s);
    iss_pop = 1; tick(); iss_pop = 0;
    chk({tag, " report valid"}, 32'(pred_iss_valid), 32'd1);
    chk({tag, " report seq"}, 32'(pred_iss_seq), 32'(s));
    chk({tag, " report store"}, 32'(pred_iss_store), 32'(st));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    repeat (3) tick();
    rst = 0;
    tick();
    // reset state, R10 R11
    cand("R7 reset", 1'b0, '0);
    chk("R11 reset full", 32'(ins_full), 0);
    chk("R10 reset ld", 32'(cnt_ins_ld), 0);
    chk("R10 reset cst", 32'(cnt_conf_st), 0);

    // R12 lookup path, R1 direct ready
    ins_pc = 16'h0030;
    #1 chk("R12 lookup pc", 32'(pred_lk_pc), 32'h30);
    ins(3, 16'h0030, 0, 1, 0, 0);
    cand("R1 no-dep ready", 1'b1, 3);
    chk("R1 pc", 32'(iss_pc), 32'h30);

    // R4 store report, R2 wait for registers
    ins(4, 16'h0040, 1, 0, 0, 0);
    chk("R4 st valid", 32'(pred_st_valid), 1);
    chk("R4 st seq", 32'(pred_st_seq), 4);
    chk("R4 st pc", 32'(pred_st_pc), 32'h40);
    pop_chk("R7 pop load", 3, 0);
    cand("R2 waiting store", 1'b0, '0);
    regs(4);
    cand("R2 after rr", 1'b1, 4);

    // R3 linking, R5 wake
    ins(6, 16'h0060, 0, 1, 0, 4);
    ins(7, 16'h0070, 0, 0, 0, 4);
    ins(8, 16'h0080, 1, 1, 0, 4);
    ins(9, 16'h0090, 0, 1, 0, 2);   // untracked producer -> no dependence
    chk("R3 conf ld", 32'(cnt_conf_ld), 2);
    chk("R3 conf st", 32'(cnt_conf_st), 1);
    pop_chk("R5 pop producer", 4, 1);
    pop_chk("R5 woken load", 6, 0);
    pop_chk("R5 woken store", 8, 1);
    pop_chk("R3 untracked producer", 9, 0);
    cand("R5 rr-pending stays", 1'b0, '0);
    regs(7);
    pop_chk("R5 rr after wake", 7, 0);

    // R6 non-speculative path
    ins(11, 16'h00b0, 0, 1, 1, 0);
    cand("R6 held at insert", 1'b0, '0);
    regs(11);
    cand("R6 rr ignored", 1'b0, '0);
    nsr_valid = 1; nsr_seq = 11; tick(); nsr_valid = 0;
    pop_chk("R6 released", 11, 0);

    // R8 squash
    ins(20, 16'h0100, 1, 0, 0, 0);
    ins(21, 16'h0110, 0, 1, 0, 20);
    ins(22, 16'h0120, 0, 1, 0, 0);
    ins(23, 16'h0130, 1, 1, 0, 0);
    cand("R8 before squash", 1'b1, 22);
    ins_valid = 1; ins_seq = 30; ins_pc = 16'h0200; ins_is_store = 0; ins_regs_rdy = 1; ins_nonspec = 0;
    squash(21);
    ins_valid = 0;
    cand("R8 younger gone, insert ignored", 1'b0, '0);
    regs(20);
    pop_chk("R8 survivor store", 20, 1);
    pop_chk("R8 survivor dependent", 21, 0);
    ins(40, 16'h0140, 1, 1, 0, 0);
    ins(41, 16'h0150, 0, 1, 0, 40);
    squash(40);
    pop_chk("R8 store after dependent squashed", 40, 1);
    cand("R8 no stale wake", 1'b0, '0);

    // R11 full sweep
    for (int k = 0; k < 16; k++) begin
      ins(SEQ_W'(50 + k), PC_W'(16'h0500 + k), 0, 0, 0, 0);
      chk("R11 full flag", 32'(ins_full), 32'(k == 15));
    end
    ins(70, 16'h0700, 0, 1, 0, 0);
    cand("R11 insert while full dropped", 1'b0, '0);
    chk("R11 count unchanged", 32'(cnt_ins_ld), 32'd24);
    regs(57);
    cand("R7 single ready", 1'b1, 57);
    regs(52);
    cand("R7 lower wins", 1'b1, 52);
    squash(0);
    chk("R8 squash all", 32'(ins_full), 0);
    cand("R8 empty", 1'b0, '0);

    // R7 permuted order sweep
    begin
      int mn;
      mn = 255;
      for (int k = 0; k < 16; k++) begin
        int s;
        s = 100 + ((k * 7) % 16);
        if (s < mn) mn = s;
        ins(SEQ_W'(s), PC_W'(s), 0, 1, 0, 0);
        cand("R7 running min", 1'b1, SEQ_W'(mn));
      end
      for (int j = 0; j < 16; j++) begin
        pop_chk("R7 ascending drain", SEQ_W'(100 + j), 0);
      end
      cand("R7 drained", 1'b0, '0);
    end

    // R9 violation forward
    vio_valid = 1; vio_load_pc = 16'hbeef; vio_store_pc = 16'h1234; tick(); vio_valid = 0;
    chk("R9 vio valid", 32'(pred_vio_valid), 1);
    chk("R9 vio load", 32'(pred_vio_load_pc), 32'hbeef);
    chk("R9 vio store", 32'(pred_vio_store_pc), 32'h1234);

    // R10 totals
    chk("R10 ins ld", 32'(cnt_ins_ld), 40);
    chk("R10 ins st", 32'(cnt_ins_st), 5);
    chk("R10 conf ld", 32'(cnt_conf_ld), 4);
    chk("R10 conf st", 32'(cnt_conf_st), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule